// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Control and Status Registers

This block turns an asynchronous serial line into bytes for a processor. Each character is a low start bit, eight data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. A clock enable that pulses sixteen times per bit period paces the receiver. A start bit counts only if the line is still low at the middle of that bit. Each finished character goes into a holding register, and a status byte reports whether the holding register is occupied and whether a parity, overrun or framing fault has been seen.

A small register bus gives the processor access to the block. It has a two-bit address, separate read and write strobes, and byte-wide write and read data. Four locations exist: the received byte (read), the status byte (read), a control byte (read/write) and a setup location (read/write). The setup location reaches two setup slots in turn through an internal pointer. The control byte does three things: it turns reception on and off, it can hold the receiver in reset, and its write-only bits can clear the fault flags or reset everything at once. The transmitter, the baud-rate source and interrupt outputs are outside this block.

Top module: `uart_rx_csr`

## Requirements
- R1: A character is a low start bit, 8 data bits least significant bit first, an optional parity bit and one or two stop bits. After it completes, a read of address 0 returns the data bits.
- R2: Status bit 7 (buffer occupied) becomes 1 when a character completes while reception is on. A read strobe at address 0 clears it.
- R3: While control bit 2 (reception on) is 0, status bit 7 is never set and the address 0 byte is not replaced. Status bits 0, 1 and 2 are cleared and held at 0.
- R4: Status bit 1 (overrun) becomes 1 when a character completes while status bit 7 is already 1. The new character replaces the old one.
- R5: Status bit 2 (framing) becomes 1 when any sampled stop bit is low.
- R6: Setup slot 0 bit 0 turns parity on and bit 1 selects odd parity (0 selects even). Status bit 0 (parity) becomes 1 when the received parity bit does not match the data.
- R7: A low pulse on the line that ends before mid-bit (8 ticks after the falling edge) produces no character.
- R8: Writing control with bit 6 set clears status bits 0, 1 and 2. Bit 6 is not stored and reads back as 0.
- R9: Control bit 3, while 1, holds the receiver idle with status at 0. Control reads back only bits 2 and 3. Bit 0 is ignored.
- R10: Writing control with bit 7 set resets the control byte, both setup slots, the status byte and the receiver, and moves the setup pointer back to slot 0.
- R11: A write at address 3 fills the setup slot selected by the pointer, then the pointer moves to the next slot and wraps after slot 1. A read at address 3 returns the selected slot. Setup slot 1 bit 0 selects two stop bits.
- R12: After reset, every register reads 0 and the setup pointer selects slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Clock enable, 16 pulses per bit period |
| rxd | input | 1 | Serial line, idle high |
| addr | input | 2 | Register address: 0 data, 1 status, 2 control, 3 setup |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register (combinational) |

## Verification
Read data follows the address in the same cycle, so the bench samples `rdata` one time step after it sets the address, still in the same cycle. A read or write strobe takes effect at the next rising edge. The bench therefore checks what a strobe did with a read in a later cycle. A character completes about half a bit after the stop bit begins, plus two synchronizer clocks. The bench holds each stop bit for a full bit period and then idles for one more bit period before it looks at status, so the flags have always settled when it reads them. The bench keeps its own model of the flags, built from the requirements. Each read is compared with that model.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned BUS_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } rx_state_t;

  // Register addresses
  localparam logic [1:0] A_DATA   = 2'd0;
  localparam logic [1:0] A_STATUS = 2'd1;
  localparam logic [1:0] A_CTRL   = 2'd2;
  localparam logic [1:0] A_SETUP  = 2'd3;

  // Fault flags, in the order they appear in status bits 2..0
  typedef struct packed {
    logic frm;
    logic ovr;
    logic par;
  } err_t;

  function automatic logic [BUS_W-1:0] status_byte(input logic full, input err_t e);
    return {full, 4'b0000, e.frm, e.ovr, e.par};
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_byte(input logic en, input logic hold);
    return {4'b0000, hold, en, 2'b00};
  endfunction
endpackage

// File: rtl/rx_deser.sv
module rx_deser #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              par_bad_o,
  output logic              frm_bad_o
);
  import uart_rx_pkg::*;
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int unsigned HALF  = OVS / 2 - 1;
  localparam int unsigned LAST  = OVS - 1;

  // Parity check: the data bits plus the parity bit must have the configured sum.
  function automatic logic parity_bad(input logic [DATA_W-1:0] d, input logic p, input logic odd);
    return ((^d) ^ p) != odd;
  endfunction

  rx_state_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              pbit, second;

  // A sample is taken on this tick (one full bit period after the previous one).
  wire samp_now = tick && (cnt == CNT_W'(LAST));
  wire mid_chk  = tick && (cnt == CNT_W'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; shreg <= '0; pbit <= 1'b0;
      second <= 1'b0; done <= 1'b0; par_bad_o <= 1'b0; frm_bad_o <= 1'b0;
    end else begin
      done <= 1'b0;
      if (srst) begin
        st <= S_IDLE; cnt <= '0; idx <= '0; second <= 1'b0;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
        unique case (st)
          S_IDLE: if (!rxd) begin st <= S_START; cnt <= '0; end
          S_START: if (mid_chk) begin
            cnt <= '0; idx <= '0;
            st  <= rxd ? S_IDLE : S_DATA;
          end
          S_DATA: if (samp_now) begin
            shreg <= {rxd, shreg[DATA_W-1:1]};
            idx   <= idx + 1'b1;
            if (idx == IDX_W'(DATA_W - 1)) begin
              st <= par_en ? S_PAR : S_STOP;
              second <= 1'b0;
            end
          end
          S_PAR: if (samp_now) begin pbit <= rxd; st <= S_STOP; end
          S_STOP: if (samp_now) begin
            if (two_stop && !second) begin
              second    <= 1'b1;
              frm_bad_o <= !rxd;
            end else begin
              st        <= S_IDLE;
              done      <= 1'b1;
              frm_bad_o <= (second && frm_bad_o) || !rxd;
              par_bad_o <= par_en && parity_bad(shreg, pbit, par_odd);
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign data = shreg;
endmodule

// File: rtl/rx_status.sv
module rx_status #(
  parameter int unsigned DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               srst,
  input  logic               rx_en,
  input  logic               done,
  input  logic [DATA_W-1:0]  cdata,
  input  logic               c_par,
  input  logic               c_frm,
  input  logic               rd_data,
  input  logic               clr_err,
  output logic               full,
  output logic [DATA_W-1:0]  buf_q,
  output uart_rx_pkg::err_t  err
);
  import uart_rx_pkg::*;
  wire  accept = done && rx_en;
  err_t err_n;

  always_comb begin
    err_n = err;
    if (clr_err) err_n = '0;
    if (accept) begin
      err_n.par = err_n.par | c_par;
      err_n.frm = err_n.frm | c_frm;
      err_n.ovr = err_n.ovr | (full && !rd_data);
    end
    if (!rx_en) err_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0; buf_q <= '0; err <= '0;
    end else if (srst) begin
      full <= 1'b0; buf_q <= '0; err <= '0;
    end else begin
      err <= err_n;
      if (accept) begin
        full  <= 1'b1;
        buf_q <= cdata;
      end else if (rd_data) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_regs.sv
module rx_regs #(
  parameter int unsigned SLOTS  = 2,
  parameter int unsigned SLOT_W = 2,
  localparam int unsigned PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_stb,
  input  logic [7:0]        wdata,
  output logic              rx_en,
  output logic              rx_hold,
  output logic              int_rst,
  output logic              clr_err,
  output logic [PTR_W-1:0]  ptr,
  output logic [SLOT_W-1:0] setup_rd,
  output logic              par_en,
  output logic              par_odd,
  output logic              two_stop
);
  import uart_rx_pkg::*;
  logic [SLOT_W-1:0] slot_q [SLOTS];

  wire ctrl_wr  = wr_stb && (addr == A_CTRL);
  wire setup_wr = wr_stb && (addr == A_SETUP);
  assign int_rst = ctrl_wr && wdata[7];
  assign clr_err = ctrl_wr && wdata[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en <= 1'b0; rx_hold <= 1'b0; ptr <= '0;
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else if (int_rst) begin
      rx_en <= 1'b0; rx_hold <= 1'b0; ptr <= '0;
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else begin
      if (ctrl_wr) begin
        rx_en   <= wdata[2];
        rx_hold <= wdata[3];
      end
      if (setup_wr) begin
        slot_q[ptr] <= wdata[SLOT_W-1:0];
        ptr <= (ptr == PTR_W'(SLOTS - 1)) ? '0 : ptr + 1'b1;
      end
    end
  end

  assign setup_rd = slot_q[ptr];
  assign par_en   = slot_q[0][0];
  assign par_odd  = slot_q[0][1];
  assign two_stop = slot_q[1][0];
endmodule

// File: rtl/uart_rx_csr.sv
module uart_rx_csr #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] addr,
  input  logic       rd_stb,
  input  logic       wr_stb,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  import uart_rx_pkg::*;
  localparam int unsigned SLOTS  = 2;
  localparam int unsigned SLOT_W = 2;
  localparam int unsigned PTR_W  = $clog2(SLOTS);

  logic [SYNC_STAGES-1:0] sync_q;
  logic rx_en, rx_hold, int_rst, clr_err, par_en, par_odd, two_stop;
  logic [PTR_W-1:0]  setup_ptr;
  logic [SLOT_W-1:0] setup_rd;
  logic              char_done, c_par, c_frm, full_q;
  logic [DATA_W-1:0] c_data, buf_q;
  err_t              err_q;

  // Named internal events, brought out for the checker
  wire       rx_srst     = rx_hold || int_rst;
  wire       rd_data_hit = rd_stb && (addr == A_DATA);
  wire [2:0] err_bits    = err_q;
  wire [7:0] ctrl_rb     = ctrl_byte(rx_en, rx_hold);

  // Line synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1; else sync_q <= rxd;
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1; else sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end
  endgenerate

  rx_regs #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_stb(wr_stb), .wdata(wdata),
    .rx_en(rx_en), .rx_hold(rx_hold), .int_rst(int_rst), .clr_err(clr_err),
    .ptr(setup_ptr), .setup_rd(setup_rd), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop)
  );

  rx_deser #(.DATA_W(DATA_W), .OVS(OVS)) u_deser (
    .clk(clk), .rst_n(rst_n), .srst(rx_srst), .tick(tick16),
    .rxd(sync_q[SYNC_STAGES-1]), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .done(char_done), .data(c_data),
    .par_bad_o(c_par), .frm_bad_o(c_frm)
  );

  rx_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .srst(rx_srst), .rx_en(rx_en), .done(char_done),
    .cdata(c_data), .c_par(c_par), .c_frm(c_frm), .rd_data(rd_data_hit),
    .clr_err(clr_err), .full(full_q), .buf_q(buf_q), .err(err_q)
  );

  always_comb begin
    unique case (addr)
      A_DATA:   rdata = 8'(buf_q);
      A_STATUS: rdata = status_byte(full_q, err_q);
      A_CTRL:   rdata = ctrl_rb;
      default:  rdata = 8'(setup_rd);
    endcase
  end
endmodule

// File: rtl/uart_rx_csr_chk.sv
module uart_rx_csr_chk #(
  parameter int unsigned PTR_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en,
  input logic             rx_hold,
  input logic             full,
  input logic [2:0]       errs,
  input logic             char_done,
  input logic             rd_data,
  input logic             clr_err,
  input logic             int_rst,
  input logic [PTR_W-1:0] ptr,
  input logic [7:0]       ctrl_rb
);
  a_r2_full_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_en && !rx_hold && !int_rst) |=> full);

  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !char_done) |=> !full);

  a_r3_no_full_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !full) |=> !full);

  a_r3_errs_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (errs == 3'b000));

  a_r4_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_en && full && !rd_data && !rx_hold && !int_rst) |=> errs[1]);

  a_r8_clear_errs: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !char_done) |=> (errs == 3'b000));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hold |=> (!full && errs == 3'b000));

  a_r10_int_reset: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |=> (ptr == '0 && ctrl_rb == 8'h00 && !full));
endmodule

bind uart_rx_csr uart_rx_csr_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_hold(rx_hold), .full(full_q),
  .errs(err_bits), .char_done(char_done), .rd_data(rd_data_hit),
  .clr_err(clr_err), .int_rst(int_rst), .ptr(setup_ptr), .ctrl_rb(ctrl_rb)
);

// File: tb/uart_rx_csr_test.sv
`timescale 1ns/1ps
module uart_rx_csr_test;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic [1:0] addr = 2'd0;
  logic rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  // Bench model of the register state
  logic       m_full = 1'b0, m_par = 1'b0, m_ovr = 1'b0, m_frm = 1'b0, m_en = 1'b0;
  logic [7:0] m_data = 8'h00;

  localparam int BITCLK = 64; // 16 ticks of 4 clocks

  uart_rx_csr uut (.clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .addr(addr),
                   .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata));

  always #2.5 clk = ~clk;

  initial begin : tickgen
    forever begin
      repeat (3) @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
    end
  end

  function automatic logic [7:0] exp_status();
    return {m_full, 4'b0000, m_frm, m_ovr, m_par};
  endfunction

  function automatic logic good_parity(input logic [7:0] d, input logic odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    return odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_stb = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic line(input logic v, input int clocks);
    rxd = v;
    repeat (clocks) @(negedge clk);
  endtask

  // Send one character; updates the model as the requirements dictate.
  task automatic send(input logic [7:0] d, input logic pe, input logic odd, input logic two,
                      input logic bad_par, input logic bad_stop);
    logic p;
    p = good_parity(d, odd) ^ bad_par;
    @(negedge clk);
    line(1'b0, BITCLK);
    for (int i = 0; i < 8; i++) line(d[i], BITCLK);
    if (pe) line(p, BITCLK);
    if (bad_stop) begin line(1'b0, 44); line(1'b1, BITCLK - 44); end
    else line(1'b1, BITCLK);
    if (two) line(1'b1, BITCLK);
    line(1'b1, BITCLK);
    if (m_en) begin
      if (m_full) m_ovr = 1'b1;
      m_full = 1'b1;
      m_data = d;
      m_par  = m_par | (pe & bad_par);
      m_frm  = m_frm | bad_stop;
    end
  endtask

  task automatic set_cfg(input logic pe, input logic odd, input logic two);
    bus_wr(2'd3, {6'b0, odd, pe});
    bus_wr(2'd3, {7'b0, two});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rv;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12 reset state
    bus_rd(2'd0, rv); check("R12 data", rv, 8'h00);
    bus_rd(2'd1, rv); check("R12 status", rv, 8'h00);
    bus_rd(2'd2, rv); check("R12 ctrl", rv, 8'h00);
    bus_rd(2'd3, rv); check("R12 setup", rv, 8'h00);

    // R11 setup pointer sequence
    bus_wr(2'd3, 8'h03);
    bus_rd(2'd3, rv); check("R11 slot1 after one write", rv, 8'h00);
    bus_wr(2'd3, 8'h01);
    bus_rd(2'd3, rv); check("R11 wrapped to slot0", rv, 8'h03);

    // R9 bit0 ignored, readback bits 2 and 3 only
    bus_wr(2'd2, 8'h37);
    bus_rd(2'd2, rv); check("R9 ctrl readback", rv, 8'h04);
    m_en = 1'b1;

    // R1 R2 R4 R5 R6 random characters
    for (int it = 0; it < 30; it++) begin
      logic pe, odd, two, bp, bs, skip;
      logic [7:0] d;
      pe = 1'($urandom); odd = 1'($urandom); two = 1'($urandom);
      d  = 8'($urandom);
      bp = pe && ($urandom % 4 == 0);
      bs = !two && ($urandom % 4 == 0);
      skip = ($urandom % 3 == 0);
      set_cfg(pe, odd, two);
      send(d, pe, odd, two, bp, bs);
      bus_rd(2'd1, rv); check("R2 R4 R5 R6 status after char", rv, exp_status());
      if (!skip) begin
        bus_rd(2'd0, rv); check("R1 data", rv, m_data);
        m_full = 1'b0;
        bus_rd(2'd1, rv); check("R2 full cleared by read", rv, exp_status());
      end
      if ((m_par | m_ovr | m_frm) && ($urandom % 2 == 0)) begin
        bus_wr(2'd2, 8'h44);
        m_par = 1'b0; m_ovr = 1'b0; m_frm = 1'b0;
        bus_rd(2'd1, rv); check("R8 errors cleared", rv, exp_status());
        bus_rd(2'd2, rv); check("R8 bit6 not stored", rv, 8'h04);
      end
    end

    // Directed overrun and framing
    set_cfg(1'b0, 1'b0, 1'b0);
    bus_rd(2'd0, rv); m_full = 1'b0;
    send(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    bus_rd(2'd1, rv); check("R4 R5 overrun and framing", rv, exp_status());
    bus_rd(2'd0, rv); check("R4 newest char kept", rv, 8'h3C);
    m_full = 1'b0;

    // R3 reception off
    bus_wr(2'd2, 8'h00); m_en = 1'b0;
    m_par = 1'b0; m_ovr = 1'b0; m_frm = 1'b0;
    bus_rd(2'd1, rv); check("R3 errors cleared when off", rv, 8'h00);
    send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    bus_rd(2'd1, rv); check("R3 no full when off", rv, 8'h00);
    bus_rd(2'd0, rv); check("R3 data not replaced", rv, 8'h3C);

    // R7 short glitch
    bus_wr(2'd2, 8'h04); m_en = 1'b1;
    line(1'b0, 16); line(1'b1, 3 * BITCLK);
    bus_rd(2'd1, rv); check("R7 glitch rejected", rv, 8'h00);

    // R9 receiver hold
    send(8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_rd(2'd1, rv); check("R9 full before hold", rv, 8'h80);
    bus_wr(2'd2, 8'h0C);
    bus_rd(2'd1, rv); check("R9 hold clears status", rv, 8'h00);
    m_en = 1'b0; m_full = 1'b0;
    send(8'h96, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_rd(2'd1, rv); check("R9 hold ignores line", rv, 8'h00);
    bus_wr(2'd2, 8'h04); m_en = 1'b1;
    bus_rd(2'd2, rv); check("R9 ctrl after release", rv, 8'h04);

    // R10 internal reset
    send(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_wr(2'd3, 8'h03);
    bus_wr(2'd2, 8'h84);
    m_en = 1'b0; m_full = 1'b0;
    bus_rd(2'd2, rv); check("R10 ctrl cleared", rv, 8'h00);
    bus_rd(2'd1, rv); check("R10 status cleared", rv, 8'h00);
    bus_rd(2'd3, rv); check("R10 slot0 cleared", rv, 8'h00);
    bus_wr(2'd3, 8'h02);
    bus_rd(2'd3, rv); check("R10 pointer restarted at slot0", rv, 8'h00);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd3, rv); check("R10 R11 slot0 holds write", rv, 8'h02);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule